// File: doc/BRIEF.md
# Virtual Group 1 End-of-Interrupt Unit

This block completes Group 1 interrupts on a virtual CPU interface. Guest software writes an interrupt number to a write-only register. Each accepted write clears the most urgent bit of the active-priority bitmap, and the running priority falls. When the EOI mode input is low, the same write also clears the active state of the matching list register. For a hardware-backed entry, the write also sends a deactivate request with the physical ID to the distributor.

The block holds a small bank of list registers. The hypervisor model loads them through a simple write port and reads them back through a combinational read port. An acknowledge input sets bits in the bitmap. While a distributor request is waiting to be accepted, the register write is held off.

Top module: `vgic_eoi_unit`

## Requirements
- R1: After reset the bitmap is empty, so `run_idle`=1 and `run_prio`=31. Every list register reads zero, `deact_valid`=0 and `wr_ready`=1.
- R2: `run_prio` is the index of the lowest-numbered set bitmap bit. When no bit is set, `run_prio` is all ones and `run_idle`=1. An `ack_valid` pulse sets bit `ack_prio`, and the bit is visible after the next edge.
- R3: An accepted write (`wr_valid`, `wr_ready`, `wr_addr`=0x24) with an ordinary ID clears the lowest-numbered set bitmap bit at the next edge. A write to any other address changes nothing.
- R4: A write whose ID (`wr_data[9:0]`) is 1020 to 1023 is ignored entirely. It causes no priority drop and no list-register change.
- R5: List-register layout: [1:0] state (0 invalid, 1 pending, 2 active, 3 pending and active), [2] HW, [3] group, [8:4] priority, [18:9] virtual ID, [28:19] physical ID, [31:29] source CPU. With `eoi_mode`=0, the lowest-indexed Group 1 entry whose state bit 1 is set and whose virtual ID matches loses state bit 1. State 2 becomes 0 and state 3 becomes 1. With `eoi_mode`=1 the list registers are unchanged and only the drop happens. Write bits 31:13 never affect the result.
- R6: For a virtual ID below 16, a match also requires `wr_data[12:10]` to equal the entry's source CPU field. For other IDs those bits are ignored.
- R7: A deactivated entry with HW=1 drives `deact_valid`=1 and `deact_pid`=physical ID after the write edge. Both hold, unchanged, until `deact_ready` is sampled high.
- R8: A deactivated HW entry whose physical ID is 1020 to 1023 is still updated but sends no request. Physical IDs 0 to 15 are forwarded normally.
- R9: A matching Group 0 entry is never deactivated. If its priority equals the current running priority and the bitmap is not empty, the write is ignored entirely. Otherwise the drop still happens.
- R10: `wr_ready` is 0 whenever `deact_valid` is 1. A write offered then has no effect.
- R11: When an acknowledge and a drop fall in the same cycle, the clear is applied first and the set second. An acknowledge of the bit being dropped leaves that bit set.
- R12: `lr_we` loads `lr_wdata` into entry `lr_widx` at the next edge. A load to an entry that is deactivated in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eoi_mode | input | 1 | 1: priority drop only; 0: drop plus deactivate |
| wr_valid | input | 1 | Register write strobe |
| wr_ready | output | 1 | Write can be accepted |
| wr_addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Written value |
| ack_valid | input | 1 | Set a bitmap bit |
| ack_prio | input | 5 | Bit to set |
| lr_we | input | 1 | List-register load strobe |
| lr_widx | input | 2 | Entry to load |
| lr_wdata | input | 32 | Entry contents |
| lr_ridx | input | 2 | Entry to read |
| lr_rdata | output | 32 | Contents of entry `lr_ridx` |
| run_prio | output | 5 | Running priority |
| run_idle | output | 1 | No active priority |
| deact_valid | output | 1 | Distributor deactivate request |
| deact_ready | input | 1 | Distributor accepts request |
| deact_pid | output | 10 | Physical ID to deactivate |

## Verification
An acknowledge that sets a bitmap bit can land in the same cycle as a priority drop that clears one. The same can happen with a list-register load and a deactivate aimed at the same entry. The bench forces both collisions by raising the two strobes in one cycle. It checks the result through the running priority and the list-register read port: the acknowledged bit must survive, including when it is the dropped bit, and the loaded word must replace the entry. A scoreboard queue holds the expected physical IDs and compares them at each distributor handshake. It also catches requests that should have been suppressed.

// File: rtl/vgic_eoi_unit.sv
module vgic_eoi_unit #(
  parameter int NUM_LR   = 4,
  parameter int PRIO_W   = 5,
  parameter int ID_W     = 10,
  parameter int ADDR_W   = 8,
  parameter int EOI_OFFS = 'h24,
  parameter int SPC_LO   = 1020
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        eoi_mode,
  input  logic                        wr_valid,
  output logic                        wr_ready,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [31:0]                 wr_data,
  input  logic                        ack_valid,
  input  logic [PRIO_W-1:0]           ack_prio,
  input  logic                        lr_we,
  input  logic [$clog2(NUM_LR)-1:0]   lr_widx,
  input  logic [4+PRIO_W+2*ID_W+2:0]  lr_wdata,
  input  logic [$clog2(NUM_LR)-1:0]   lr_ridx,
  output logic [4+PRIO_W+2*ID_W+2:0]  lr_rdata,
  output logic [PRIO_W-1:0]           run_prio,
  output logic                        run_idle,
  output logic                        deact_valid,
  input  logic                        deact_ready,
  output logic [ID_W-1:0]             deact_pid
);
  localparam int APR_W   = 1 << PRIO_W;
  localparam int IDX_W   = $clog2(NUM_LR);
  localparam int LR_W    = 4 + PRIO_W + 2*ID_W + 3;
  localparam int HW_B    = 2;
  localparam int GRP_B   = 3;
  localparam int PR_LSB  = 4;
  localparam int VID_LSB = PR_LSB + PRIO_W;
  localparam int PID_LSB = VID_LSB + ID_W;
  localparam int SRC_LSB = PID_LSB + ID_W;

  logic [LR_W-1:0]   lr_q [NUM_LR];
  logic [APR_W-1:0]  apr_q;
  logic [PRIO_W-1:0] top_prio;
  logic [NUM_LR-1:0] match;
  logic [IDX_W-1:0]  sel;
  logic [LR_W-1:0]   mw;
  logic [ID_W-1:0]   wid, mpid;
  logic [2:0]        wsrc;
  logic hit, wid_spc, pid_spc, any_m, g0_block, accept, do_deact, fwd;
  logic [APR_W-1:0]  drop_mask, set_mask;
  logic unused_hi;

  assign unused_hi = ^wr_data[31:13];

  always_comb begin
    top_prio = '1;
    for (int i = APR_W-1; i >= 0; i--)
      if (apr_q[i]) top_prio = PRIO_W'(i);
  end
  assign run_idle = (apr_q == '0);
  assign run_prio = top_prio;

  assign wr_ready = !deact_valid;
  assign hit      = wr_valid && wr_ready && (wr_addr == ADDR_W'(EOI_OFFS));
  assign wid      = wr_data[ID_W-1:0];
  assign wsrc     = wr_data[12:10];
  assign wid_spc  = (wid >= ID_W'(SPC_LO)) && (wid <= ID_W'(SPC_LO + 3));

  for (genvar g = 0; g < NUM_LR; g++) begin : g_match
    logic [ID_W-1:0] vid;
    assign vid = lr_q[g][VID_LSB +: ID_W];
    assign match[g] = lr_q[g][1] && (vid == wid) &&
                      ((vid >= ID_W'(16)) || (lr_q[g][SRC_LSB +: 3] == wsrc));
  end

  always_comb begin
    sel = '0;
    for (int i = NUM_LR-1; i >= 0; i--)
      if (match[i]) sel = IDX_W'(i);
  end
  assign any_m   = |match;
  assign mw      = lr_q[sel];
  assign mpid    = mw[PID_LSB +: ID_W];
  assign pid_spc = (mpid >= ID_W'(SPC_LO)) && (mpid <= ID_W'(SPC_LO + 3));

  assign g0_block  = any_m && !mw[GRP_B] && !run_idle && (mw[PR_LSB +: PRIO_W] == top_prio);
  assign accept    = hit && !wid_spc && !g0_block;
  assign drop_mask = (accept && !run_idle) ? (APR_W'(1) << top_prio) : '0;
  assign set_mask  = ack_valid ? (APR_W'(1) << ack_prio) : '0;
  assign do_deact  = accept && !eoi_mode && any_m && mw[GRP_B];
  assign fwd       = do_deact && mw[HW_B] && !pid_spc;

  always_ff @(posedge clk) begin
    if (!rst_n) apr_q <= '0;
    else        apr_q <= (apr_q & ~drop_mask) | set_mask;
  end

  for (genvar g = 0; g < NUM_LR; g++) begin : g_lr
    always_ff @(posedge clk) begin
      if (!rst_n)
        lr_q[g] <= '0;
      else if (lr_we && (lr_widx == IDX_W'(g)))
        lr_q[g] <= lr_wdata;
      else if (do_deact && (sel == IDX_W'(g)))
        lr_q[g][1] <= 1'b0;
    end
  end

  assign lr_rdata = lr_q[lr_ridx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deact_valid <= 1'b0;
      deact_pid   <= '0;
    end else if (fwd) begin
      deact_valid <= 1'b1;
      deact_pid   <= mpid;
    end else if (deact_ready) begin
      deact_valid <= 1'b0;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    deact_valid && !deact_ready |=> deact_valid && $stable(deact_pid));

  p_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    deact_valid |-> !wr_ready);

  p_nospecial_r8: assert property (@(posedge clk) disable iff (!rst_n)
    deact_valid |-> (deact_pid < ID_W'(SPC_LO)) || (deact_pid > ID_W'(SPC_LO + 3)));

  p_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !wid_spc && !any_m && !run_idle && !ack_valid
    |=> $countones(apr_q) == $countones($past(apr_q)) - 1);

  p_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit && wid_spc && !ack_valid |=> apr_q == $past(apr_q));

  p_ackset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> apr_q[$past(ack_prio)]);
endmodule

// File: tb/vgic_eoi_unit_bench.sv
module vgic_eoi_unit_bench;
  logic clk = 0, rst_n = 0;
  logic eoi_mode = 0, wr_valid = 0, ack_valid = 0, lr_we = 0, deact_ready = 1;
  logic [7:0] wr_addr = 0;
  logic [31:0] wr_data = 0, lr_wdata = 0, lr_rdata;
  logic [4:0] ack_prio = 0, run_prio;
  logic [1:0] lr_widx = 0, lr_ridx = 0;
  logic wr_ready, run_idle, deact_valid;
  logic [9:0] deact_pid;
  int nchk = 0, nfail = 0;
  logic [9:0] exp_q[$];

  always #4 clk = ~clk;

  vgic_eoi_unit u_vgic_eoi_unit (
    .clk, .rst_n, .eoi_mode, .wr_valid, .wr_ready, .wr_addr, .wr_data,
    .ack_valid, .ack_prio, .lr_we, .lr_widx, .lr_wdata, .lr_ridx, .lr_rdata,
    .run_prio, .run_idle, .deact_valid, .deact_ready, .deact_pid);

  function automatic logic [31:0] mk(int st, int hw, int grp, int pr, int vid, int pid, int src);
    return {src[2:0], pid[9:0], vid[9:0], pr[4:0], grp[0], hw[0], st[1:0]};
  endfunction

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick; @(posedge clk); #2; endtask

  task automatic load(int idx, logic [31:0] w);
    lr_we = 1; lr_widx = idx[1:0]; lr_wdata = w; tick; lr_we = 0;
  endtask

  task automatic ack(int p);
    ack_valid = 1; ack_prio = p[4:0]; tick; ack_valid = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    while (!wr_ready) tick;
    wr_valid = 1; wr_addr = a; wr_data = d; tick; wr_valid = 0;
  endtask

  task automatic eoi(logic [31:0] d); wr(8'h24, d); endtask

  task automatic rd(int idx, output logic [31:0] w);
    lr_ridx = idx[1:0]; #1; w = lr_rdata;
  endtask

  task automatic drain; while (!run_idle) eoi(999); endtask

  always @(negedge clk) begin
    if (rst_n && deact_valid && deact_ready) begin
      nchk++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL R7: actual request pid %0d expected none", deact_pid);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        if (deact_pid != e) begin
          nfail++;
          $display("FAIL R7: actual pid %0d expected %0d", deact_pid, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] w;
    repeat (3) tick;
    rst_n = 1; tick;
    // R1
    chk("R1 idle", run_idle, 1); chk("R1 prio", run_prio, 31);
    chk("R1 ready", wr_ready, 1); chk("R1 valid", deact_valid, 0);
    rd(0, w); chk("R1 lr", w, 0);
    // R2
    ack(9); ack(5);
    chk("R2 prio", run_prio, 5); chk("R2 idle", run_idle, 0);
    // R3 R5
    load(0, mk(2, 0, 1, 5, 40, 0, 0));
    eoi(40);
    rd(0, w); chk("R5 cleared", w[1:0], 0); chk("R3 drop", run_prio, 9);
    load(1, mk(3, 0, 1, 9, 41, 0, 0));
    eoi_mode = 1; eoi(41);
    rd(1, w); chk("R5 mode1 unchanged", w[1:0], 3); chk("R5 mode1 drop", run_idle, 1);
    eoi_mode = 0; eoi(32'hFFFF_FC00 | 41);
    rd(1, w); chk("R5 3to1 high bits ignored", w[1:0], 1); chk("R2 empty stays", run_prio, 31);
    // R3 offset
    ack(5); wr(8'h20, 999);
    chk("R3 other offset", run_prio, 5);
    eoi(999); chk("R3 drop", run_idle, 1);
    // R6
    load(2, mk(2, 0, 1, 4, 3, 0, 2));
    ack(4); eoi((5 << 10) | 3);
    rd(2, w); chk("R6 src mismatch", w[1:0], 2); chk("R6 drop", run_idle, 1);
    ack(4); eoi((2 << 10) | 3);
    rd(2, w); chk("R6 src match", w[1:0], 0);
    // R7 R10
    load(3, mk(2, 1, 1, 7, 100, 200, 0));
    ack(7); deact_ready = 0; exp_q.push_back(200);
    eoi(100);
    chk("R7 valid", deact_valid, 1); chk("R7 pid", deact_pid, 200); chk("R10 ready", wr_ready, 0);
    ack(2);
    wr_valid = 1; wr_addr = 8'h24; wr_data = 999; tick; tick; wr_valid = 0;
    chk("R7 held", deact_valid, 1); chk("R7 pid held", deact_pid, 200);
    chk("R10 blocked write", run_prio, 2);
    deact_ready = 1; tick;
    chk("R7 released", deact_valid, 0); chk("R7 queue", exp_q.size(), 0);
    drain;
    // R8
    load(0, mk(2, 1, 1, 3, 50, 1021, 0));
    eoi(50); tick;
    rd(0, w); chk("R8 special lr", w[1:0], 0); chk("R8 no request", deact_valid, 0);
    load(1, mk(2, 1, 1, 3, 60, 7, 0));
    exp_q.push_back(7); eoi(60); tick;
    chk("R8 sgi pid forwarded", exp_q.size(), 0);
    // R4
    ack(3); load(2, mk(2, 0, 1, 3, 1022, 0, 0));
    eoi(1022);
    chk("R4 no drop", run_prio, 3);
    rd(2, w); chk("R4 lr kept", w[1:0], 2);
    drain;
    // R9
    ack(3); load(2, mk(2, 0, 0, 3, 70, 0, 0));
    eoi(70);
    chk("R9 ignored", run_prio, 3);
    ack(1); eoi(70);
    chk("R9 drop", run_prio, 3);
    rd(2, w); chk("R9 group0 kept", w[1:0], 2);
    drain;
    // R11
    ack(6);
    ack_valid = 1; ack_prio = 6; wr_valid = 1; wr_addr = 8'h24; wr_data = 999; tick;
    ack_valid = 0; wr_valid = 0;
    chk("R11 same bit", run_prio, 6);
    ack_valid = 1; ack_prio = 8; wr_valid = 1; tick;
    ack_valid = 0; wr_valid = 0;
    chk("R11 other bit", run_prio, 8);
    drain;
    // R12
    ack(1); load(0, mk(2, 0, 1, 1, 80, 0, 0));
    lr_we = 1; lr_widx = 0; lr_wdata = mk(2, 0, 1, 1, 81, 0, 0);
    wr_valid = 1; wr_addr = 8'h24; wr_data = 80; tick;
    lr_we = 0; wr_valid = 0;
    rd(0, w); chk("R12 load wins state", w[1:0], 2); chk("R12 load wins vid", w[18:9], 81);
    chk("R12 drop", run_idle, 1);
    tick;
    chk("R7 queue end", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule